// File: doc/BRIEF.md
# Thread Interrupt Pending Buffer Context

This block holds the interrupt context of one hardware thread. The context is split into four privilege rings (user, OS, pool and physical). Each ring keeps an eight-bit pending buffer with one bit per priority level and a current-priority register. Notifications tagged with a ring and a priority set the matching pending bit. The block raises a hypervisor-level or OS-level exception output whenever a ring holds a pending priority more favored than its current priority.

Software reaches the rings through a register port addressed by page, ring and field. The page gives the privilege of the access: the hardware page sees every ring, and each less privileged page loses sight of the next most privileged ring. An acknowledge read hands out the most favored pending priority, consumes it and raises the ring's current priority to that level. The exception output for the ring then drops.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset every pending buffer reads 0, every current priority reads 0xFF, `hv_irq` and `os_irq` are low and `rvalid` is low.
- R2: A notification of priority p in 0..7 ORs bit (7 - p) into the pending buffer of ring `ntf_ring` at the next clock edge. Ring codes are 0 user, 1 OS, 2 pool and 3 physical, and the other bits of the buffer are kept.
- R3: A notification with a priority above 7 changes no pending buffer.
- R4: A ring signals when its most favored pending priority (the lowest number among the set bits) is numerically below its current priority. `hv_irq` is the OR of the physical and pool rings' signals, and `os_irq` is the OS ring's signal. The user ring drives no output.
- R5: A write of the current priority changes the state at that clock edge, and the outputs are re-evaluated against the pending buffer from that edge on.
- R6: An acknowledge read returns the most favored pending priority, or 0xFF if the buffer is empty. In the same edge it clears that bit and sets the current priority to it. An acknowledge of an empty buffer changes nothing.
- R7: Page codes are 0 hardware, 1 hypervisor, 2 OS and 3 user. Page p may access ring r only when p + r <= 3. A denied write is ignored, and a denied read, including an acknowledge, returns 0 and changes nothing.
- R8: Field codes are 0 pending buffer (read/write), 1 current priority (read/write), 2 acknowledge (read only, writes ignored) and 3 reserved (reads 0, writes ignored).
- R9: A read returns its data on `rdata` with `rvalid` high one cycle after the request. In any other cycle `rvalid` is low and `rdata` is 0.
- R10: When a notification and an access hit the same ring in one cycle, the access takes effect first and the notification bit is ORed in afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_ring | input | 2 | Ring the notification targets |
| ntf_prio | input | PRIO_W | Priority of the notification |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_page | input | 2 | Privilege page of the access |
| acc_ring | input | 2 | Ring addressed |
| acc_field | input | 2 | Register field addressed |
| acc_wdata | input | PRIO_W | Write data |
| rdata | output | PRIO_W | Read data, registered |
| rvalid | output | 1 | Read data valid |
| hv_irq | output | 1 | Hypervisor-level exception (pool or physical ring) |
| os_irq | output | 1 | OS-level exception (OS ring) |

## Verification
The assertions assume the inputs are two-state and stable around each rising edge. They also assume that the only actions able to move the exception outputs are a notification, a permitted write or a permitted acknowledge, so their stability checks apply only to cycles that carry no notification. The bench drives every input at the falling edge from a seeded random sequence. It varies page, ring and field uniformly, and it spreads priorities and written current priorities over both legal levels and values above 7, including 0xFF.

// File: rtl/tipb_pkg.sv
package tipb_pkg;
   localparam int unsigned RING_CNT = 4;

   localparam logic [1:0] RING_USER = 2'd0;
   localparam logic [1:0] RING_OS   = 2'd1;
   localparam logic [1:0] RING_POOL = 2'd2;
   localparam logic [1:0] RING_PHYS = 2'd3;

   localparam logic [1:0] PAGE_HW   = 2'd0;
   localparam logic [1:0] PAGE_USER = 2'd3;

   typedef enum logic [1:0] {
      FLD_PEND = 2'd0,
      FLD_CPPR = 2'd1,
      FLD_ACK  = 2'd2,
      FLD_RSVD = 2'd3
   } field_e;
endpackage

// File: rtl/tipb_prio_dec.sv
module tipb_prio_dec #(
   parameter int unsigned LEVELS = 8,
   parameter int unsigned PW     = 8
) (
   input  logic [PW-1:0]     prio,
   output logic [LEVELS-1:0] bits
);
   always_comb begin
      bits = '0;
      for (int i = 0; i < LEVELS; i++)
         if (prio == PW'(LEVELS - 1 - i)) bits[i] = 1'b1;
   end
endmodule

// File: rtl/tipb_prio_enc.sv
module tipb_prio_enc #(
   parameter int unsigned LEVELS = 8,
   parameter int unsigned PW     = 8
) (
   input  logic [LEVELS-1:0] bits,
   output logic [PW-1:0]     prio
);
   always_comb begin
      prio = '1;
      for (int i = 0; i < LEVELS; i++)
         if (bits[i]) prio = PW'(LEVELS - 1 - i);
   end
endmodule

// File: rtl/tipb_ring.sv
module tipb_ring #(
   parameter int unsigned LEVELS = 8,
   parameter int unsigned PW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] ntf_bits,
   input  logic              wr_pend,
   input  logic              wr_cppr,
   input  logic              ack,
   input  logic [PW-1:0]     wdata,
   output logic [LEVELS-1:0] pend,
   output logic [PW-1:0]     cppr,
   output logic [PW-1:0]     fav
);
   logic [LEVELS-1:0] ack_bits;
   logic [LEVELS-1:0] pend_base;
   logic [LEVELS-1:0] pend_d;
   logic [PW-1:0]     cppr_d;

   tipb_prio_enc #(.LEVELS(LEVELS), .PW(PW)) u_enc (.bits(pend), .prio(fav));
   tipb_prio_dec #(.LEVELS(LEVELS), .PW(PW)) u_dec (.prio(fav), .bits(ack_bits));

   always_comb begin
      if (wr_pend)  pend_base = wdata[LEVELS-1:0];
      else if (ack) pend_base = pend & ~ack_bits;
      else          pend_base = pend;
      pend_d = pend_base | ntf_bits;

      if (wr_cppr)                 cppr_d = wdata;
      else if (ack && fav != '1)   cppr_d = fav;
      else                         cppr_d = cppr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         cppr <= '1;
      end else begin
         pend <= pend_d;
         cppr <= cppr_d;
      end
   end
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx
   import tipb_pkg::*;
#(
   parameter int unsigned PRIO_LEVELS = 8,
   parameter int unsigned PRIO_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ntf_valid,
   input  logic [1:0]        ntf_ring,
   input  logic [PRIO_W-1:0] ntf_prio,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_page,
   input  logic [1:0]        acc_ring,
   input  logic [1:0]        acc_field,
   input  logic [PRIO_W-1:0] acc_wdata,
   output logic [PRIO_W-1:0] rdata,
   output logic              rvalid,
   output logic              hv_irq,
   output logic              os_irq
);
   if (PRIO_LEVELS > PRIO_W) begin : g_bad_width
      $error("PRIO_LEVELS must fit in PRIO_W bits");
   end
   if (PRIO_LEVELS >= (1 << PRIO_W) - 1) begin : g_bad_levels
      $error("all-ones priority must lie beyond the active levels");
   end

   logic [PRIO_LEVELS-1:0] ntf_dec;
   logic [PRIO_LEVELS-1:0] pend_a [RING_CNT];
   logic [PRIO_W-1:0]      cppr_a [RING_CNT];
   logic [PRIO_W-1:0]      fav_a  [RING_CNT];
   logic [RING_CNT-1:0]    allowed;
   logic                   rd_req;
   logic [PRIO_W-1:0]      rd_d;
   field_e                 fld;

   assign fld    = field_e'(acc_field);
   assign rd_req = acc_valid && !acc_write;

   tipb_prio_dec #(.LEVELS(PRIO_LEVELS), .PW(PRIO_W)) u_ntf_dec (
      .prio(ntf_prio), .bits(ntf_dec));

   for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
      logic hit;
      assign allowed[r] = ({1'b0, acc_page} + 3'(r)) <= 3'd3;
      assign hit = acc_valid && acc_ring == 2'(r) && allowed[r];

      tipb_ring #(.LEVELS(PRIO_LEVELS), .PW(PRIO_W)) u_ring (
         .clk      (clk),
         .rst_n    (rst_n),
         .ntf_bits ((ntf_valid && ntf_ring == 2'(r)) ? ntf_dec : '0),
         .wr_pend  (hit && acc_write && fld == FLD_PEND),
         .wr_cppr  (hit && acc_write && fld == FLD_CPPR),
         .ack      (hit && !acc_write && fld == FLD_ACK),
         .wdata    (acc_wdata),
         .pend     (pend_a[r]),
         .cppr     (cppr_a[r]),
         .fav      (fav_a[r]));
   end

   always_comb begin
      rd_d = '0;
      if (rd_req && allowed[acc_ring]) begin
         case (fld)
            FLD_PEND: rd_d = PRIO_W'(pend_a[acc_ring]);
            FLD_CPPR: rd_d = cppr_a[acc_ring];
            FLD_ACK:  rd_d = fav_a[acc_ring];
            default:  rd_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rdata  <= rd_d;
         rvalid <= rd_req;
      end
   end

   assign hv_irq = (fav_a[RING_PHYS] < cppr_a[RING_PHYS]) ||
                   (fav_a[RING_POOL] < cppr_a[RING_POOL]);
   assign os_irq = fav_a[RING_OS] < cppr_a[RING_OS];
endmodule

// File: rtl/tipb_checker.sv
module tipb_checker #(
   parameter int unsigned PRIO_LEVELS = 8,
   parameter int unsigned PRIO_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ntf_valid,
   input logic [PRIO_W-1:0] ntf_prio,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [1:0]        acc_page,
   input logic [1:0]        acc_ring,
   input logic [1:0]        acc_field,
   input logic [PRIO_W-1:0] rdata,
   input logic              rvalid,
   input logic              hv_irq,
   input logic              os_irq
);
   logic denied;
   assign denied = ({1'b0, acc_page} + {1'b0, acc_ring}) > 3'd3;

   // R1: outputs are quiet in the first cycle out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!hv_irq && !os_irq && !rvalid));

   // R3: an out-of-range notification alone moves no output
   assert_bad_prio_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_valid && ntf_prio >= PRIO_W'(PRIO_LEVELS) && !acc_valid)
      |=> ($stable(hv_irq) && $stable(os_irq)));

   // R6: acknowledging the OS ring drops its exception
   assert_ack_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && acc_field == 2'd2 && acc_ring == 2'd1 &&
       !denied && !ntf_valid) |=> !os_irq);

   // R7: a denied access changes nothing and reads zero
   assert_denied_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && denied && !ntf_valid)
      |=> ($stable(hv_irq) && $stable(os_irq)));
   assert_denied_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && denied) |=> (rdata == '0));

   // R9: read data handshake
   assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |=> rvalid);
   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_write) |=> (!rvalid && rdata == '0));
endmodule

bind thread_irq_ctx tipb_checker #(.PRIO_LEVELS(PRIO_LEVELS), .PRIO_W(PRIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
   .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
   .acc_ring(acc_ring), .acc_field(acc_field), .rdata(rdata),
   .rvalid(rvalid), .hv_irq(hv_irq), .os_irq(os_irq));

// File: tb/sim_thread_irq_ctx.sv
module sim_thread_irq_ctx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ntf_valid = 1'b0;
   logic [1:0] ntf_ring = '0;
   logic [7:0] ntf_prio = '0;
   logic       acc_valid = 1'b0;
   logic       acc_write = 1'b0;
   logic [1:0] acc_page = '0;
   logic [1:0] acc_ring = '0;
   logic [1:0] acc_field = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] rdata;
   logic       rvalid;
   logic       hv_irq;
   logic       os_irq;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] m_pend [4];
   logic [7:0] m_cppr [4];

   always #5 clk = ~clk;

   thread_irq_ctx u0 (.*);

   function automatic logic [7:0] m_bit(input logic [7:0] p);
      return (p <= 8'd7) ? 8'(1 << (7 - p)) : 8'h00;
   endfunction

   function automatic logic [7:0] m_fav(input logic [7:0] pb);
      for (int p = 0; p < 8; p++) if (pb[7 - p]) return 8'(p);
      return 8'hFF;
   endfunction

   function automatic logic m_exc(input int r);
      return m_fav(m_pend[r]) < m_cppr[r];
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic op(input logic nv, input logic [1:0] nr, input logic [7:0] np,
                     input logic av, input logic aw, input logic [1:0] pg,
                     input logic [1:0] rg, input logic [1:0] fd,
                     input logic [7:0] wd, input string tag);
      logic [7:0] rd_exp;
      logic       ok;
      logic       is_rd;
      ntf_valid = nv; ntf_ring = nr; ntf_prio = np;
      acc_valid = av; acc_write = aw; acc_page = pg; acc_ring = rg;
      acc_field = fd; acc_wdata = wd;
      is_rd  = av && !aw;
      ok     = (int'(pg) + int'(rg)) <= 3;
      rd_exp = 8'h00;
      if (is_rd && ok)
         case (fd)
            2'd0: rd_exp = m_pend[rg];
            2'd1: rd_exp = m_cppr[rg];
            2'd2: rd_exp = m_fav(m_pend[rg]);
            default: rd_exp = 8'h00;
         endcase
      if (av && ok) begin
         if (aw && fd == 2'd0) m_pend[rg] = wd;
         if (aw && fd == 2'd1) m_cppr[rg] = wd;
         if (!aw && fd == 2'd2 && m_fav(m_pend[rg]) != 8'hFF) begin
            m_cppr[rg] = m_fav(m_pend[rg]);
            m_pend[rg] = m_pend[rg] & ~m_bit(m_cppr[rg]);
         end
      end
      if (nv) m_pend[nr] = m_pend[nr] | m_bit(np);
      @(posedge clk);
      @(negedge clk);
      chk({7'd0, rvalid}, {7'd0, is_rd}, {tag, " R9 rvalid"});
      chk(rdata, rd_exp, {tag, " rdata"});
      chk({7'd0, hv_irq}, {7'd0, m_exc(3) || m_exc(2)}, {tag, " R4 hv_irq"});
      chk({7'd0, os_irq}, {7'd0, m_exc(1)}, {tag, " R4 os_irq"});
      ntf_valid = 1'b0; acc_valid = 1'b0;
   endtask

   task automatic rd(input logic [1:0] pg, input logic [1:0] rg,
                     input logic [1:0] fd, input string tag);
      op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, pg, rg, fd, 8'd0, tag);
   endtask

   task automatic wr(input logic [1:0] pg, input logic [1:0] rg,
                     input logic [1:0] fd, input logic [7:0] wd, input string tag);
      op(1'b0, 2'd0, 8'd0, 1'b1, 1'b1, pg, rg, fd, wd, tag);
   endtask

   task automatic ntf(input logic [1:0] nr, input logic [7:0] np, input string tag);
      op(1'b1, nr, np, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 8'd0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      for (int r = 0; r < 4; r++) begin m_pend[r] = 8'h00; m_cppr[r] = 8'hFF; end
      repeat (3) @(negedge clk);
      chk({7'd0, rvalid}, 8'd0, "R1 rvalid");
      rst_n = 1'b1;
      chk({6'd0, hv_irq, os_irq}, 8'd0, "R1 outputs");
      for (int r = 0; r < 4; r++) begin
         rd(2'd0, 2'(r), 2'd0, "R1 pend");
         rd(2'd0, 2'(r), 2'd1, "R1 cppr");
      end
      // R2: priority 3 on the OS ring sets bit 4
      ntf(2'd1, 8'd3, "R2 notify");
      rd(2'd0, 2'd1, 2'd0, "R2 pend");
      chk(rdata, 8'h10, "R2 bit position");
      // R3: out-of-range priority
      ntf(2'd1, 8'd9, "R3 prio9");
      ntf(2'd2, 8'hFF, "R3 prioFF");
      rd(2'd0, 2'd1, 2'd0, "R3 pend");
      rd(2'd0, 2'd2, 2'd0, "R3 pend pool");
      // R5: current priority writes
      wr(2'd2, 2'd1, 2'd1, 8'd3, "R5 cppr eq");
      wr(2'd2, 2'd1, 2'd1, 8'd4, "R5 cppr above");
      // R7: privilege
      wr(2'd3, 2'd1, 2'd1, 8'd0, "R7 denied write");
      rd(2'd0, 2'd1, 2'd1, "R7 cppr kept");
      rd(2'd3, 2'd1, 2'd0, "R7 denied read");
      rd(2'd2, 2'd2, 2'd2, "R7 denied ack");
      // R6: acknowledge
      ntf(2'd1, 8'd6, "R6 second");
      rd(2'd2, 2'd1, 2'd2, "R6 ack");
      chk(rdata, 8'd3, "R6 ack value");
      rd(2'd0, 2'd1, 2'd0, "R6 pend after");
      rd(2'd0, 2'd1, 2'd1, "R6 cppr after");
      wr(2'd0, 2'd1, 2'd0, 8'h00, "R6 clear");
      rd(2'd2, 2'd1, 2'd2, "R6 ack empty");
      // R8: reserved and acknowledge-write
      rd(2'd0, 2'd3, 2'd3, "R8 reserved");
      wr(2'd0, 2'd3, 2'd2, 8'd0, "R8 ack write");
      wr(2'd0, 2'd3, 2'd3, 8'd0, "R8 rsvd write");
      rd(2'd0, 2'd3, 2'd1, "R8 cppr kept");
      // R10: same-cycle notification and acknowledge
      ntf(2'd3, 8'd5, "R10 setup");
      op(1'b1, 2'd3, 8'd5, 1'b1, 1'b0, 2'd0, 2'd3, 2'd2, 8'd0, "R10 ack+ntf");
      rd(2'd0, 2'd3, 2'd0, "R10 pend");
      ntf(2'd3, 8'd1, "R10 more favored");
      // R4: user ring drives nothing
      ntf(2'd0, 8'd0, "R4 user ring");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] np, wd;
         np = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8);
         case ($urandom % 3)
            0: wd = 8'($urandom);
            1: wd = 8'($urandom % 10);
            default: wd = 8'hFF;
         endcase
         op(1'($urandom), 2'($urandom), np, 1'($urandom), 1'($urandom),
            2'($urandom), 2'($urandom), 2'($urandom), wd, "rand R2 R6 R7 R10");
      end
      finish_run();
   end
endmodule